// File: doc/BRIEF.md
# Pulse-Interval Bit Decoder

This block turns a pulse-pause-modulated envelope line into a stream of bits. A reader marks each bit by the spacing between two rising edges of the envelope. The decoder brings the asynchronous line into the clock domain and looks for rising edges. It times each gap with a tick counter and sorts the gap into one of three classes: a one, a zero, or neither. Each valid gap gives a single-cycle bit strobe with the bit value. The end of a frame is reported by a separate strobe.

The counter advances only on cycles where the tick enable input is high. The decode windows are therefore counted in ticks, and the system clock frequency does not matter. A frame closes in one of two ways: a gap falls outside both windows while a frame is open, or the line stays silent for too long. After a long idle period the counter stops at a fixed limit and stays there, so an old count can never look like a fresh valid gap. With the default parameters a one is nominally 150 ticks, a zero 90 ticks, each window is ±20 ticks, and the counter parks at 3000 ticks.

Top module: `pulse_interval_decoder`

## Requirements
- R1: After reset, `bit_valid`, `frame_end` and `frame_active` are low and the tick counter is parked. A rising edge is then ignored, whatever the time since reset.
- R2: The gap is measured from one rising edge to the next, and each rising edge restarts the count. How long the line stays high does not affect the result.
- R3: A gap strictly greater than 130 ticks and strictly less than 170 ticks gives one `bit_valid` pulse with `bit_value` = 1.
- R4: A gap strictly greater than 70 ticks and strictly less than 110 ticks gives one `bit_valid` pulse with `bit_value` = 0.
- R5: If a frame is open and a rising edge ends a gap outside both windows, the block gives one `frame_end` pulse and no bit. This includes the boundary values 70, 110, 130 and 170.
- R6: If no frame is open, a rising edge that ends an out-of-window gap gives neither a bit nor a `frame_end` pulse.
- R7: If a frame is open and the count reaches 170 ticks with no rising edge, one `frame_end` pulse is given. It appears about 170 cycles after the last edge, not sooner, and it is not repeated.
- R8: Every valid bit sets `frame_active`. `bit_valid` is never high in two cycles in a row, and it is only high while `frame_active` is high.
- R9: The counter advances only on cycles where `tick_en` is high, so the windows are counted in ticks and not in clock cycles.
- R10: The counter stops at 3000 ticks and does not wrap. A gap of 4246 ticks, which would wrap to 150 in a 12-bit counter, is treated as invalid.
- R11: `frame_active` goes low in the same cycle that `frame_end` pulses. `frame_end` and `bit_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the interval counter by one tick |
| env_in | input | 1 | Asynchronous envelope line from the demodulator |
| bit_valid | output | 1 | Single-cycle strobe: a bit was decoded |
| bit_value | output | 1 | Value of the decoded bit, valid with `bit_valid` |
| frame_end | output | 1 | Single-cycle strobe: the current frame has closed |
| frame_active | output | 1 | High while a frame is open |

## Verification
The assertions check the invariants that must hold on every cycle. The counter never goes past its park value. It holds its value when no tick arrives and reads zero right after an edge. A bit strobe lasts one cycle and only occurs inside an open frame. The end strobe never coincides with a bit, and it marks the exact cycle in which the frame flag falls. Which gaps fall inside or outside the windows can only be shown by the directed scenarios, because the assertions do not test the window contents. The same holds for the exact timing of the silence timeout, for gaps counted in ticks rather than cycles, and for a long idle gap not aliasing after a wrap.

// File: rtl/pid_pkg.sv
package pid_pkg;

    // Registered state of the frame tracker
    typedef struct packed {
        logic active;
        logic bit_stb;
        logic bit_val;
        logic end_stb;
    } frame_st_t;

endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);

    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/pid_timer.sv
module pid_timer #(
    parameter int CNT_W = 12,
    parameter int PARK  = 3000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] PARK_C = CNT_W'(PARK);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)                        cnt_d = '0;
        else if (tick_en && cnt_q != PARK_C) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= PARK_C;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R10
    cnt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= PARK_C);

    // R2
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick_en) |=> $stable(cnt_q));

endmodule

// File: rtl/pid_classify.sv
module pid_classify
    import pid_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int ONE_LO  = 130,
    parameter int ONE_HI  = 170,
    parameter int ZERO_LO = 70,
    parameter int ZERO_HI = 110,
    parameter int TIMEOUT = 170
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic [CNT_W-1:0] cnt,
    output logic             bit_valid,
    output logic             bit_value,
    output logic             frame_end,
    output logic             frame_active
);

    localparam logic [CNT_W-1:0] ONE_LO_C  = CNT_W'(ONE_LO);
    localparam logic [CNT_W-1:0] ONE_HI_C  = CNT_W'(ONE_HI);
    localparam logic [CNT_W-1:0] ZERO_LO_C = CNT_W'(ZERO_LO);
    localparam logic [CNT_W-1:0] ZERO_HI_C = CNT_W'(ZERO_HI);
    localparam logic [CNT_W-1:0] TMO_C     = CNT_W'(TIMEOUT);

    frame_st_t st_d, st_q;
    logic      in_one, in_zero;

    always_comb begin
        in_one  = (cnt > ONE_LO_C)  && (cnt < ONE_HI_C);
        in_zero = (cnt > ZERO_LO_C) && (cnt < ZERO_HI_C);

        st_d         = st_q;
        st_d.bit_stb = 1'b0;
        st_d.end_stb = 1'b0;

        if (rise) begin
            if (in_one || in_zero) begin
                st_d.bit_stb = 1'b1;
                st_d.bit_val = in_one;
                st_d.active  = 1'b1;
            end else if (st_q.active) begin
                st_d.end_stb = 1'b1;
                st_d.active  = 1'b0;
            end
        end else if (st_q.active && (cnt >= TMO_C)) begin
            st_d.end_stb = 1'b1;
            st_d.active  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_valid    = st_q.bit_stb;
    assign bit_value    = st_q.bit_val;
    assign frame_end    = st_q.end_stb;
    assign frame_active = st_q.active;

    // R8
    bit_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> frame_active);

    // R8
    bit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R11
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> (!frame_active && $past(frame_active)));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_end && bit_valid));

endmodule

// File: rtl/pulse_interval_decoder.sv
module pulse_interval_decoder #(
    parameter int ONE_NOM   = 150,
    parameter int ZERO_NOM  = 90,
    parameter int TOL       = 20,
    parameter int PARK_MULT = 20,
    parameter int SYNC_STG  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic env_in,
    output logic bit_valid,
    output logic bit_value,
    output logic frame_end,
    output logic frame_active
);

    localparam int PARK  = ONE_NOM * PARK_MULT;
    localparam int CNT_W = $clog2(PARK + 1);

    logic             rise;
    logic [CNT_W-1:0] cnt;

    pid_sync #(
        .STAGES (SYNC_STG)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (env_in),
        .rise  (rise)
    );

    pid_timer #(
        .CNT_W (CNT_W),
        .PARK  (PARK)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (rise),
        .cnt     (cnt)
    );

    pid_classify #(
        .CNT_W   (CNT_W),
        .ONE_LO  (ONE_NOM - TOL),
        .ONE_HI  (ONE_NOM + TOL),
        .ZERO_LO (ZERO_NOM - TOL),
        .ZERO_HI (ZERO_NOM + TOL),
        .TIMEOUT (ONE_NOM + TOL)
    ) i_classify (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise         (rise),
        .cnt          (cnt),
        .bit_valid    (bit_valid),
        .bit_value    (bit_value),
        .frame_end    (frame_end),
        .frame_active (frame_active)
    );

endmodule

// File: tb/test_pulse_interval_decoder.sv
`timescale 1ns/1ps
module test_pulse_interval_decoder;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic env_in = 1'b0;
    logic bit_valid, bit_value, frame_end, frame_active;
    logic tick_gate = 1'b0;

    int total = 0;
    int bad = 0;
    int nbits = 0;
    int nends = 0;
    int bits [0:15];
    logic prev_active = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pulse_interval_decoder i_pulse_interval_decoder (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .env_in       (env_in),
        .bit_valid    (bit_valid),
        .bit_value    (bit_value),
        .frame_end    (frame_end),
        .frame_active (frame_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // tick enable: every cycle, or every other cycle when gated
    always @(posedge clk) begin
        #1;
        tick_en = tick_gate ? ~tick_en : 1'b1;
    end

    // monitor sampled on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid) begin
                if (nbits < 16) bits[nbits] = int'(bit_value);
                nbits++;
            end
            if (frame_end) begin
                nends++;
                // R11 active falls with the end strobe
                check(!frame_active && prev_active, "R11", int'(frame_active), 0);
            end
            prev_active = frame_active;
        end
    end

    // rising edge now, then the next rising edge v cycles later; line high for hi cycles
    task automatic rise_gap(input int v, input int hi);
        env_in = 1'b1;
        repeat (hi) @(posedge clk);
        #1 env_in = 1'b0;
        repeat (v + 1 - hi) @(posedge clk);
        #1;
    endtask

    task automatic clear_counts();
        nbits = 0;
        nends = 0;
    endtask

    // starter edge, then gaps g[0..n-1], then a closing edge followed by idle
    task automatic run_frame(input int g [0:7], input int n, input int hi, input int idle);
        clear_counts();
        for (int i = 0; i < n; i++) rise_gap(g[i], hi);
        rise_gap(idle, hi);
    endtask

    task automatic expect_bits(input string req, input int exp [0:7], input int n, input int ends);
        check(nbits == n, req, nbits, n);
        for (int i = 0; i < n && i < nbits; i++)
            check(bits[i] == exp[i], req, bits[i], exp[i]);
        check(nends == ends, req, nends, ends);
    endtask

    task automatic t_reset();
        int g [0:7];
        check(!bit_valid && !frame_end && !frame_active, "R1",
              int'({bit_valid, frame_end, frame_active}), 0);
        // first edge 150 cycles after reset: counter parked, so ignored
        repeat (148) @(posedge clk);
        #1;
        g = '{default: 0};
        clear_counts();
        rise_gap(250, 3);
        check(nbits == 0 && nends == 0, "R1", nbits + nends, 0);
        check(!frame_active, "R1", int'(frame_active), 0);
        g[0] = 0;
    endtask

    task automatic t_ones();
        int g [0:7];
        int e [0:7];
        g = '{150, 131, 169, 0, 0, 0, 0, 0};
        e = '{1, 1, 1, 0, 0, 0, 0, 0};
        run_frame(g, 3, 3, 300);
        expect_bits("R3", e, 3, 1);
    endtask

    task automatic t_zeros();
        int g [0:7];
        int e [0:7];
        g = '{90, 71, 109, 0, 0, 0, 0, 0};
        e = '{0, 0, 0, 0, 0, 0, 0, 0};
        run_frame(g, 3, 3, 300);
        expect_bits("R4", e, 3, 1);
    endtask

    task automatic t_mixed_wide_high();
        int g [0:7];
        int e [0:7];
        // R2: line held high for 60 cycles, only rising edges count
        g = '{150, 90, 90, 150, 90, 0, 0, 0};
        e = '{1, 0, 0, 1, 0, 0, 0, 0};
        run_frame(g, 5, 60, 300);
        expect_bits("R2", e, 5, 1);
    endtask

    task automatic t_boundary(input int first, input int edge_v, input int first_bit);
        int g [0:7];
        int e [0:7];
        g = '{first, edge_v, 0, 0, 0, 0, 0, 0};
        e = '{first_bit, 0, 0, 0, 0, 0, 0, 0};
        run_frame(g, 2, 3, 300);
        // R5 boundary gap closes the open frame, no extra timeout end
        expect_bits("R5", e, 1, 1);
        check(!frame_active, "R5", int'(frame_active), 0);
    endtask

    task automatic t_idle_invalid();
        int g [0:7];
        int e [0:7];
        g = '{50, 200, 0, 0, 0, 0, 0, 0};
        e = '{default: 0};
        run_frame(g, 2, 3, 300);
        expect_bits("R6", e, 0, 0);
        check(!frame_active, "R6", int'(frame_active), 0);
    endtask

    task automatic t_timeout();
        clear_counts();
        rise_gap(150, 3);
        // last edge, then silence
        env_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 env_in = 1'b0;
        repeat (162) @(posedge clk);
        #1;
        check(nbits == 1, "R7", nbits, 1);
        check(nends == 0, "R7", nends, 0);
        check(frame_active, "R7", int'(frame_active), 1);
        repeat (15) @(posedge clk);
        #1;
        check(nends == 1, "R7", nends, 1);
        repeat (300) @(posedge clk);
        #1;
        check(nends == 1, "R7", nends, 1);
    endtask

    task automatic t_ticks();
        int g [0:7];
        int e [0:7];
        tick_gate = 1'b1;
        // 300 cycles = 150 ticks -> one; 150 cycles = 75 ticks -> zero
        g = '{300, 150, 0, 0, 0, 0, 0, 0};
        e = '{1, 0, 0, 0, 0, 0, 0, 0};
        run_frame(g, 2, 3, 600);
        expect_bits("R9", e, 2, 1);
        tick_gate = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic t_park();
        int g [0:7];
        int e [0:7];
        // 4246 would alias to 150 in a wrapping 12-bit counter
        g = '{4246, 150, 0, 0, 0, 0, 0, 0};
        e = '{1, 0, 0, 0, 0, 0, 0, 0};
        run_frame(g, 2, 3, 300);
        expect_bits("R10", e, 1, 1);
    endtask

    task automatic t_strobe_width();
        int g [0:7];
        int e [0:7];
        // R8 two quick bits, each a single pulse, frame flag raised
        g = '{90, 90, 0, 0, 0, 0, 0, 0};
        e = '{0, 0, 0, 0, 0, 0, 0, 0};
        clear_counts();
        rise_gap(90, 3);
        rise_gap(90, 3);
        env_in = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        check(frame_active, "R8", int'(frame_active), 1);
        check(nbits == 2, "R8", nbits, 2);
        env_in = 1'b0;
        repeat (300) @(posedge clk);
        #1;
        expect_bits("R8", e, 2, 1);
        g[0] = 0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ones();
        t_zeros();
        t_mixed_wide_high();
        t_boundary(150, 130, 1);
        t_boundary(150, 170, 1);
        t_boundary(90, 70, 0);
        t_boundary(90, 110, 0);
        t_idle_invalid();
        t_timeout();
        t_ticks();
        t_park();
        t_strobe_width();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule